// File: doc/BRIEF.md
# Sample FIFO Write Port for a Converter Buffer

This block runs a 16-entry, 12-bit sample buffer as a first-in first-out queue in front of a digital-to-analog converter. Software stores samples through bus writes of 8, 16 or 32 bits. Each write that passes the width and alignment rules puts its data at the write position, and the write position then moves forward. Each conversion trigger takes the oldest sample, places it on the held converter output, and moves the read position forward. The block reports full, empty, not-full and watermark flags, which it works out from the two positions and one extra wrap bit on each.

The queue runs only while the buffer-enable input is high. A rising edge on that input puts the block into queue mode: the write position is set equal to the read position, so the queue starts empty. Software can also load the write position directly. Loading it with the current read position empties the queue again. Data reads address any buffer entry and move neither position. Writes are accepted while conversion is disabled. Only the triggers wait for the conversion-enable input.

Top module: `smpq_fifo_port`

## Requirements
- R1: After reset, both positions are 0, `empty`=1, `full`=0, `not_full`=1 and `dac_out`=0.
- R2: While `buf_en`=0, writes and triggers have no effect. In the first cycle with `buf_en`=1 after it was 0, the write position is loaded with the read position, the queue becomes empty, and that cycle's write and trigger are dropped.
- R3: A 16-bit write (`wr_size`=1) with `wr_addr[1]`=0 stores `wr_data[11:0]` at the write position and advances it by 1. When `wr_addr[1]`=1 the write is ignored.
- R4: A 32-bit write (`wr_size`=2) at an even write position stores `wr_data[11:0]` at the position and `wr_data[23:12]` at the position plus 1, then advances the position by 2. At an odd write position the write is ignored. `wr_size`=3 is always ignored.
- R5: An 8-bit write (`wr_size`=0) with `wr_addr[1]`=0 fills one half of a sample. With `wr_addr[0]`=0 it fills bits 7:0 from `wr_data[7:0]`. With `wr_addr[0]`=1 it fills bits 11:8 from `wr_data[3:0]`. The sample is stored, and the position advances, only once both halves are present, in either order. An 8-bit write with `wr_addr[1]`=1 is ignored.
- R6: When the queue holds 16 samples, every write is ignored. When it holds 15, a 32-bit write is ignored.
- R7: A trigger while `buf_en`=1, `conv_en`=1 and the queue is not empty loads the entry at the read position into `dac_out` on the next clock edge. The read position then advances modulo 16.
- R8: A trigger on an empty queue, or while `conv_en`=0, leaves `dac_out` and the read position unchanged. Writes are still accepted while `conv_en`=0.
- R9: `rd_data` shows the entry addressed by `rd_addr` in the same cycle, and reads move neither position.
- R10: `wp_set` loads `wp_val` into the write position, and the fill level becomes (`wp_val` − read position) mod 16. This also drops a half-written byte sample. Loading the read position's value empties the queue.
- R11: `wm_flag` is 1 exactly when the fill level is less than or equal to `wm_level`.
- R12: `full` is 1 at a fill level of 16, `empty` is 1 at a fill level of 0, and `not_full` is the inverse of `full`. `full` and `empty` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| buf_en | input | 1 | Buffer enable; a rising edge enters queue mode |
| conv_en | input | 1 | Conversion enable; gates the triggers |
| trig | input | 1 | Conversion trigger, one pulse per sample |
| wr_en | input | 1 | Bus write strobe for the data range |
| wr_size | input | 2 | Access width: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| wr_addr | input | 2 | Low two byte-address bits of the access |
| wr_data | input | 24 | Write data packed as two 12-bit lanes |
| wp_set | input | 1 | Load the write position from `wp_val` |
| wp_val | input | 4 | New write position |
| wm_level | input | 5 | Watermark fill level |
| rd_addr | input | 4 | Entry index for data reads |
| rd_data | output | 12 | Entry at `rd_addr` |
| dac_out | output | 12 | Held converter sample |
| wptr | output | 4 | Write position |
| rptr | output | 4 | Read position |
| full | output | 1 | Queue holds 16 samples |
| empty | output | 1 | Queue holds no samples |
| not_full | output | 1 | At least one slot is free |
| wm_flag | output | 1 | Fill level is at or below `wm_level` |

## Verification
The bench aims at the cases where a 32-bit write must be dropped: one at an odd position, and one with a single free slot. A design that accepted either would store a sample past the read position and show a corrupt fill level. It writes the two byte halves in reverse order and puts a misaligned byte write between them. A design that did not track the halves separately would either store a sample too early or merge in the wrong byte. It also drains a full queue across the wrap, then loads the write position and re-enters queue mode while a half sample is pending. A design with a wrong wrap bit or a stale pending byte would report the wrong flags or store a merged sample.

// File: rtl/smpq_pkg.sv
package smpq_pkg;

   typedef enum logic [1:0] {
      ACC_B8  = 2'd0,
      ACC_B16 = 2'd1,
      ACC_B32 = 2'd2,
      ACC_RSV = 2'd3
   } acc_size_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/smpq_wr_decode.sv
module smpq_wr_decode
   import smpq_pkg::*;
#(
   parameter int unsigned SMP_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               accept_ok,
   input  logic               wr_en,
   input  logic [1:0]         wr_size,
   input  logic [1:0]         wr_addr,
   input  logic [2*SMP_W-1:0] wr_data,
   input  logic               wp_odd,
   input  logic               room_none,
   input  logic               room_one,
   output logic [1:0]         push_cnt,
   output logic [SMP_W-1:0]   push_d0,
   output logic [SMP_W-1:0]   push_d1
);

   localparam int unsigned HI_W = SMP_W - 8;

   acc_size_e          sz;
   logic               lane_ok;
   logic               byte_take;
   logic [7:0]         lo_q;
   logic [HI_W-1:0]    hi_q;
   logic               lo_vld, hi_vld;

   assign sz      = acc_size_e'(wr_size);
   assign lane_ok = ~wr_addr[1];

   always_comb begin
      push_cnt  = 2'd0;
      push_d0   = wr_data[SMP_W-1:0];
      push_d1   = wr_data[2*SMP_W-1:SMP_W];
      byte_take = 1'b0;
      if (accept_ok && wr_en && !room_none) begin
         case (sz)
            ACC_B16: if (lane_ok) push_cnt = 2'd1;
            ACC_B32: if (!wp_odd && !room_one) push_cnt = 2'd2;
            ACC_B8: begin
               if (lane_ok) begin
                  byte_take = 1'b1;
                  if (wr_addr[0] ? lo_vld : hi_vld) begin
                     push_cnt = 2'd1;
                     push_d0  = wr_addr[0] ? {wr_data[HI_W-1:0], lo_q}
                                           : {hi_q, wr_data[7:0]};
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         lo_vld <= 1'b0;
         hi_vld <= 1'b0;
      end else if (flush) begin
         lo_vld <= 1'b0;
         hi_vld <= 1'b0;
      end else if (byte_take) begin
         if (push_cnt != 2'd0) begin
            lo_vld <= 1'b0;
            hi_vld <= 1'b0;
         end else if (wr_addr[0]) begin
            hi_q   <= wr_data[HI_W-1:0];
            hi_vld <= 1'b1;
         end else begin
            lo_q   <= wr_data[7:0];
            lo_vld <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/smpq_ptr_ctrl.sv
module smpq_ptr_ctrl #(
   parameter int unsigned DEPTH    = 16,
   parameter bit          WM_BELOW = 1'b1,
   localparam int unsigned PTR_W   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             buf_en,
   input  logic             conv_en,
   input  logic             trig,
   input  logic             wp_set,
   input  logic [PTR_W-1:0] wp_val,
   input  logic [1:0]       push_cnt,
   input  logic [PTR_W:0]   wm_level,
   output logic             enter,
   output logic             pop,
   output logic [PTR_W-1:0] wptr,
   output logic [PTR_W-1:0] rptr,
   output logic             full,
   output logic             empty,
   output logic             room_one,
   output logic             wm_flag
);

   logic             buf_en_q;
   logic [PTR_W:0]   wq, rq;
   logic [PTR_W:0]   fill;
   logic             load_wrap;

   assign enter     = buf_en & ~buf_en_q;
   assign fill      = wq - rq;
   assign full      = (fill == (PTR_W+1)'(DEPTH));
   assign empty     = (fill == '0);
   assign room_one  = (fill == (PTR_W+1)'(DEPTH - 1));
   assign pop       = buf_en & ~enter & ~wp_set & conv_en & trig & ~empty;
   assign load_wrap = (wp_val >= rq[PTR_W-1:0]) ? rq[PTR_W] : ~rq[PTR_W];
   assign wptr      = wq[PTR_W-1:0];
   assign rptr      = rq[PTR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_en_q <= 1'b0;
         wq       <= '0;
         rq       <= '0;
      end else begin
         buf_en_q <= buf_en;
         if (enter)
            wq <= rq;
         else if (buf_en && wp_set)
            wq <= {load_wrap, wp_val};
         else
            wq <= wq + (PTR_W+1)'(push_cnt);
         if (pop)
            rq <= rq + 1'b1;
      end
   end

   generate
      if (WM_BELOW) begin : g_wm_low
         assign wm_flag = (fill <= wm_level);
      end else begin : g_wm_high
         assign wm_flag = (fill >= wm_level);
      end
   endgenerate

endmodule

// File: rtl/smpq_store.sv
module smpq_store #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned SMP_W  = 12,
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PTR_W-1:0] wptr,
   input  logic [1:0]       push_cnt,
   input  logic [SMP_W-1:0] push_d0,
   input  logic [SMP_W-1:0] push_d1,
   input  logic             pop,
   input  logic [PTR_W-1:0] rptr,
   input  logic [PTR_W-1:0] rd_addr,
   output logic [SMP_W-1:0] rd_data,
   output logic [SMP_W-1:0] dac_out
);

   logic [DEPTH-1:0][SMP_W-1:0] ent;
   logic [PTR_W-1:0]            wptr_nx;
   logic [SMP_W-1:0]            dac_q;

   assign wptr_nx = wptr + 1'b1;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_cell
         localparam logic [PTR_W-1:0] IDX = PTR_W'(g);
         logic [SMP_W-1:0] cell_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cell_q <= '0;
            else if ((push_cnt != 2'd0) && (wptr == IDX))
               cell_q <= push_d0;
            else if ((push_cnt == 2'd2) && (wptr_nx == IDX))
               cell_q <= push_d1;
         end
         assign ent[g] = cell_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dac_q <= '0;
      else if (pop)
         dac_q <= ent[rptr];
   end

   assign rd_data = ent[rd_addr];
   assign dac_out = dac_q;

endmodule

// File: rtl/smpq_fifo_port.sv
module smpq_fifo_port #(
   parameter int unsigned DEPTH    = 16,
   parameter int unsigned SMP_W    = 12,
   parameter bit          WM_BELOW = 1'b1,
   localparam int unsigned PTR_W   = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               buf_en,
   input  logic               conv_en,
   input  logic               trig,
   input  logic               wr_en,
   input  logic [1:0]         wr_size,
   input  logic [1:0]         wr_addr,
   input  logic [2*SMP_W-1:0] wr_data,
   input  logic               wp_set,
   input  logic [PTR_W-1:0]   wp_val,
   input  logic [PTR_W:0]     wm_level,
   input  logic [PTR_W-1:0]   rd_addr,
   output logic [SMP_W-1:0]   rd_data,
   output logic [SMP_W-1:0]   dac_out,
   output logic [PTR_W-1:0]   wptr,
   output logic [PTR_W-1:0]   rptr,
   output logic               full,
   output logic               empty,
   output logic               not_full,
   output logic               wm_flag
);

   generate
      if (!smpq_pkg::is_pow2(DEPTH) || DEPTH < 4) begin : g_bad_depth
         $error("smpq_fifo_port: DEPTH must be a power of two, at least 4");
      end
      if (SMP_W < 9 || SMP_W > 16) begin : g_bad_width
         $error("smpq_fifo_port: SMP_W must lie in 9..16");
      end
   endgenerate

   logic             enter, pop, room_one;
   logic             accept_ok, flush;
   logic [1:0]       push_cnt;
   logic [SMP_W-1:0] push_d0, push_d1;

   assign accept_ok = buf_en & ~enter & ~wp_set;
   assign flush     = ~buf_en | enter | wp_set;
   assign not_full  = ~full;

   smpq_wr_decode #(.SMP_W(SMP_W)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .accept_ok (accept_ok),
      .wr_en     (wr_en),
      .wr_size   (wr_size),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wp_odd    (wptr[0]),
      .room_none (full),
      .room_one  (room_one),
      .push_cnt  (push_cnt),
      .push_d0   (push_d0),
      .push_d1   (push_d1)
   );

   smpq_ptr_ctrl #(.DEPTH(DEPTH), .WM_BELOW(WM_BELOW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .buf_en   (buf_en),
      .conv_en  (conv_en),
      .trig     (trig),
      .wp_set   (wp_set),
      .wp_val   (wp_val),
      .push_cnt (push_cnt),
      .wm_level (wm_level),
      .enter    (enter),
      .pop      (pop),
      .wptr     (wptr),
      .rptr     (rptr),
      .full     (full),
      .empty    (empty),
      .room_one (room_one),
      .wm_flag  (wm_flag)
   );

   smpq_store #(.DEPTH(DEPTH), .SMP_W(SMP_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wptr     (wptr),
      .push_cnt (push_cnt),
      .push_d0  (push_d0),
      .push_d1  (push_d1),
      .pop      (pop),
      .rptr     (rptr),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .dac_out  (dac_out)
   );

endmodule

// File: rtl/smpq_fifo_chk.sv
module smpq_fifo_chk #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned SMP_W  = 12,
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             buf_en,
   input logic             conv_en,
   input logic             trig,
   input logic             wr_en,
   input logic [1:0]       wr_size,
   input logic             wp_set,
   input logic [PTR_W-1:0] wptr,
   input logic [PTR_W-1:0] rptr,
   input logic             full,
   input logic             empty,
   input logic [SMP_W-1:0] dac_out
);

   AST_ENTRY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_en) |=> empty);                                          // R2

   AST_ODD_W32_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_size == 2'd2 && wptr[0] && !wp_set && $stable(buf_en))
      |=> $stable(wptr));                                                // R4

   AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!wp_set && $stable(buf_en))
      |=> (PTR_W'(wptr - $past(wptr)) <= PTR_W'(2)));                    // R4

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !wp_set && $stable(buf_en)) |=> $stable(wptr));  // R6

   AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && conv_en && buf_en && !empty && !wp_set && $stable(buf_en))
      |=> (rptr == PTR_W'($past(rptr) + 1'b1)));                         // R7

   AST_EMPTY_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && trig) |=> ($stable(dac_out) && $stable(rptr)));          // R8

   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));                                                 // R12

endmodule

bind smpq_fifo_port smpq_fifo_chk #(.DEPTH(DEPTH), .SMP_W(SMP_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .buf_en  (buf_en),
   .conv_en (conv_en),
   .trig    (trig),
   .wr_en   (wr_en),
   .wr_size (wr_size),
   .wp_set  (wp_set),
   .wptr    (wptr),
   .rptr    (rptr),
   .full    (full),
   .empty   (empty),
   .dac_out (dac_out)
);

// File: tb/smpq_fifo_port_bench.sv
module smpq_fifo_port_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        buf_en = 1'b0, conv_en = 1'b0, trig = 1'b0;
   logic        wr_en = 1'b0, wp_set = 1'b0;
   logic [1:0]  wr_size = 2'd0, wr_addr = 2'd0;
   logic [23:0] wr_data = '0;
   logic [3:0]  wp_val = '0, rd_addr = '0;
   logic [4:0]  wm_level = '0;
   logic [11:0] rd_data, dac_out;
   logic [3:0]  wptr, rptr;
   logic        full, empty, not_full, wm_flag;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   smpq_fifo_port u_smpq_fifo_port (
      .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .conv_en(conv_en), .trig(trig),
      .wr_en(wr_en), .wr_size(wr_size), .wr_addr(wr_addr), .wr_data(wr_data),
      .wp_set(wp_set), .wp_val(wp_val), .wm_level(wm_level), .rd_addr(rd_addr),
      .rd_data(rd_data), .dac_out(dac_out), .wptr(wptr), .rptr(rptr),
      .full(full), .empty(empty), .not_full(not_full), .wm_flag(wm_flag)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] sz, input logic [1:0] a, input logic [23:0] d);
      wr_en = 1'b1; wr_size = sz; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic fire();
      trig = 1'b1;
      tick();
      trig = 1'b0;
   endtask

   task automatic peek(input logic [3:0] idx, input string req, input logic [11:0] exp);
      rd_addr = idx;
      #1;
      check(req, "rd_data", rd_data, exp);
   endtask

   task automatic t_reset();
      check("R1", "wptr", wptr, 0);
      check("R1", "rptr", rptr, 0);
      check("R1", "empty", empty, 1);
      check("R1", "full", full, 0);
      check("R1", "not_full", not_full, 1);
      check("R1", "dac_out", dac_out, 0);
      check("R11", "wm_flag at 0", wm_flag, 1);
   endtask

   task automatic t_disabled_then_enter();
      wr(2'd1, 2'd0, 24'h000ABC);
      check("R2", "wptr while disabled", wptr, 0);
      buf_en = 1'b1; conv_en = 1'b1;
      tick();
      check("R2", "empty after entry", empty, 1);
   endtask

   task automatic t_w16();
      wr(2'd1, 2'd0, 24'h000ABC);
      check("R3", "wptr after 16b", wptr, 1);
      peek(4'd0, "R3", 12'hABC);
      wr(2'd1, 2'd2, 24'h000111);
      check("R3", "wptr after misaligned 16b", wptr, 1);
      wr(2'd1, 2'd0, 24'h000123);
      check("R3", "wptr after second 16b", wptr, 2);
   endtask

   task automatic t_w32();
      wr(2'd2, 2'd0, 24'h456789);
      check("R4", "wptr after 32b", wptr, 4);
      peek(4'd2, "R4", 12'h789);
      peek(4'd3, "R4", 12'h456);
      wr(2'd1, 2'd0, 24'h000005);
      wr(2'd2, 2'd0, 24'h222111);
      check("R4", "wptr after odd 32b", wptr, 5);
      peek(4'd5, "R4", 12'h000);
      wr(2'd3, 2'd0, 24'h000333);
      check("R4", "wptr after reserved size", wptr, 5);
   endtask

   task automatic t_bytes();
      wr(2'd0, 2'd1, 24'h00000A);
      check("R5", "wptr after high half", wptr, 5);
      wr(2'd0, 2'd0, 24'h0000BC);
      check("R5", "wptr after pair", wptr, 6);
      peek(4'd5, "R5", 12'hABC);
      wr(2'd0, 2'd2, 24'h000011);
      wr(2'd0, 2'd1, 24'h000003);
      check("R5", "wptr after misaligned byte", wptr, 6);
      wr(2'd0, 2'd0, 24'h000044);
      check("R5", "wptr after second pair", wptr, 7);
      peek(4'd6, "R5", 12'h344);
   endtask

   task automatic t_read();
      peek(4'd3, "R9", 12'h456);
      tick();
      check("R9", "wptr after read", wptr, 7);
      check("R9", "rptr after read", rptr, 0);
   endtask

   task automatic t_trigger();
      fire();
      check("R7", "dac_out pop 1", dac_out, 12'hABC);
      check("R7", "rptr pop 1", rptr, 1);
      conv_en = 1'b0;
      fire();
      check("R8", "dac_out conv off", dac_out, 12'hABC);
      check("R8", "rptr conv off", rptr, 1);
      wr(2'd1, 2'd0, 24'h000EEE);
      check("R8", "write accepted conv off", wptr, 8);
      wp_set = 1'b1; wp_val = 4'd7;
      tick();
      wp_set = 1'b0;
      check("R10", "wptr load back", wptr, 7);
      conv_en = 1'b1;
      fire();
      fire();
      check("R7", "dac_out pop 3", dac_out, 12'h789);
      check("R7", "rptr pop 3", rptr, 3);
   endtask

   task automatic t_wm();
      wm_level = 5'd4; #1;
      check("R11", "wm at level", wm_flag, 1);
      wm_level = 5'd3; #1;
      check("R11", "wm above level", wm_flag, 0);
   endtask

   task automatic t_full();
      for (int k = 0; k < 11; k++) wr(2'd1, 2'd0, 24'h000200 + 24'(k));
      check("R6", "wptr at 15", wptr, 2);
      wr(2'd2, 2'd0, 24'h333444);
      check("R6", "32b with one slot", wptr, 2);
      check("R12", "not_full at 15", not_full, 1);
      wr(2'd1, 2'd0, 24'h0002FF);
      check("R12", "full", full, 1);
      check("R12", "not_full when full", not_full, 0);
      check("R12", "empty when full", empty, 0);
      wr(2'd1, 2'd0, 24'h000777);
      check("R6", "wptr write on full", wptr, 3);
      peek(4'd3, "R6", 12'h456);
   endtask

   task automatic t_drain();
      for (int k = 0; k < 4; k++) fire();
      check("R7", "dac_out after 4 pops", dac_out, 12'h344);
      for (int k = 0; k < 12; k++) fire();
      check("R7", "dac_out last", dac_out, 12'h2FF);
      check("R7", "rptr wrapped", rptr, 3);
      check("R12", "empty after drain", empty, 1);
      fire();
      check("R8", "dac_out on empty", dac_out, 12'h2FF);
      check("R8", "rptr on empty", rptr, 3);
   endtask

   task automatic t_wp_load();
      wr(2'd1, 2'd0, 24'h0000AA);
      check("R10", "wptr before load", wptr, 4);
      wr(2'd0, 2'd0, 24'h000055);
      wp_set = 1'b1; wp_val = 4'd3;
      tick();
      wp_set = 1'b0;
      check("R10", "wptr loaded", wptr, 3);
      check("R10", "empty after load", empty, 1);
      wr(2'd0, 2'd1, 24'h000006);
      check("R10", "pending dropped", wptr, 3);
      wr(2'd0, 2'd0, 24'h000077);
      check("R10", "wptr after new pair", wptr, 4);
      peek(4'd3, "R10", 12'h677);
   endtask

   task automatic t_reenter();
      fire();
      check("R7", "dac_out after reload", dac_out, 12'h677);
      wr(2'd1, 2'd0, 24'h000001);
      wr(2'd1, 2'd0, 24'h000002);
      check("R2", "wptr before exit", wptr, 6);
      buf_en = 1'b0;
      tick();
      wr(2'd1, 2'd0, 24'h000003);
      fire();
      check("R2", "wptr while off", wptr, 6);
      check("R2", "rptr while off", rptr, 4);
      buf_en = 1'b1;
      tick();
      check("R2", "wptr on re-entry", wptr, 4);
      check("R2", "empty on re-entry", empty, 1);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_disabled_then_enter();
      t_w16();
      t_w32();
      t_bytes();
      t_read();
      t_trigger();
      t_wm();
      t_full();
      t_drain();
      t_wp_load();
      t_reenter();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule